// File: doc/BRIEF.md
# Register Window Occupancy Tracker

This block holds the bookkeeping state that decides whether a register-window processor may rotate its window on a call or a return. It keeps four window counters, a 6-bit trap-selection register and the current window pointer. One operation is accepted per cycle. The operations are: move to a new window, move back to the previous window, request a flush of all windows, note that a window was spilled to memory, note that a window was filled from memory, and write one of the state registers.

When a move is not allowed, the block leaves all state as it is and raises a one-cycle trap request. The request carries a 9-bit type code. For spill and fill traps the code also depends on whether windows belonging to another context are still resident, and on one of two 3-bit fields of the trap-selection register. The window pointer reads back in reversed numbering, so the reversal stays out of the datapath that uses the pointer.

Top module: `win_state_unit`

## Requirements
- R1: After reset, the free-window count equals NWIN-2. The refillable, clean and foreign counts and the trap-selection register are 0. The pointer reads NWIN-1, and no trap is raised.
- R2: A move-in (op_code 1) with a nonzero free count, where the clean count differs from the refillable count, does three things: free count -1, refillable count +1, and the pointer read value +1, wrapping from NWIN-1 to 0.
- R3: A move-in with a free count of 0 raises a spill trap and changes no counter, register or pointer.
- R4: A move-in with a nonzero free count and a clean count equal to the refillable count raises a trap of type CLEAN_BASE and changes no state.
- R5: A spill or fill trap type is the base code ORed with one of two values. If the foreign count is nonzero, the value is 0x20 ORed with trap_sel bits 5:3 placed at bits 4:2. Otherwise it is trap_sel bits 2:0 placed at bits 4:2.
- R6: A move-out (op_code 2) with a refillable count of 0 raises a fill trap and changes no state. Otherwise it adds 1 to the free count, subtracts 1 from the refillable count, and lowers the pointer read value by 1, wrapping from 0 to NWIN-1.
- R7: A flush request (op_code 3) changes no state. It raises a spill trap unless the free count equals NWIN-2.
- R8: A spilled-note (op_code 4) adds 1 to the free count. It then subtracts 1 from the foreign count when that count is nonzero, and from the refillable count otherwise.
- R9: A filled-note (op_code 5) adds 1 to the refillable count. It adds 1 to the clean count only while that count is below NWIN-1. It then subtracts 1 from the foreign count when that count is nonzero, and from the free count otherwise.
- R10: Writing the pointer (op_code 6, wr_sel 5) stores wr_data modulo NWIN. The pointer read value afterwards equals wr_data mod NWIN.
- R11: A trap request is a single-cycle pulse in the cycle after the operation. With op_valid low, or with op_code 0, no state changes and no trap is raised.
- R12: A write (op_code 6) loads wr_data into one register, chosen by wr_sel: 0 free, 1 refillable, 2 clean, 3 foreign, 4 trap_sel (6 bits). Codes 6 and 7 change nothing. Counters wrap modulo 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | 0 none, 1 move-in, 2 move-out, 3 flush, 4 spilled, 5 filled, 6 write |
| wr_sel | input | 3 | Register chosen by a write |
| wr_data | input | DW (8) | Write value |
| free_cnt | output | CW (5) | Windows available for move-in |
| refill_cnt | output | CW (5) | Windows available for move-out |
| clean_cnt | output | CW (5) | Windows known to hold no stale data |
| foreign_cnt | output | CW (5) | Windows held by another context |
| trap_sel | output | 6 | Trap-selection register |
| ptr_rd | output | CWPW (3) | Window pointer, reversed numbering |
| trap_valid | output | 1 | One-cycle trap request |
| trap_type | output | TTW (9) | Trap type code |

## Verification
The bench targets the places where a wrong design goes quietly astray:
- The clean-window check ahead of a move-in. A design that tests only the free count would rotate into a dirty window.
- Choosing the trap_sel field from the foreign count. A swapped choice yields trap codes that differ in bits 5:2.
- Saturating the clean count at NWIN-1, and wrapping the pointer at both ends. Errors there show up as an overrun count or a pointer stuck at an edge.
- Routing the spilled and filled notes to the foreign count or to the other counter. An error there drifts the counters apart.

Random mixes of all operations are checked cycle by cycle against a reference model in the bench.

// File: rtl/wsu_pkg.sv
// Package: shared operation and write-select encodings for the window
// state tracker. Assumes a 3-bit operation code and a 3-bit selector.
package wsu_pkg;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_MOVE_IN  = 3'd1,
        OP_MOVE_OUT = 3'd2,
        OP_FLUSH    = 3'd3,
        OP_SPILLED  = 3'd4,
        OP_FILLED   = 3'd5,
        OP_WRITE    = 3'd6,
        OP_RSVD     = 3'd7
    } wsu_op_e;

    typedef enum logic [2:0] {
        SEL_FREE    = 3'd0,
        SEL_REFILL  = 3'd1,
        SEL_CLEAN   = 3'd2,
        SEL_FOREIGN = 3'd3,
        SEL_TSEL    = 3'd4,
        SEL_PTR     = 3'd5,
        SEL_RSVD6   = 3'd6,
        SEL_RSVD7   = 3'd7
    } wsu_sel_e;

endpackage

// File: rtl/wsu_trap_unit.sv
// Trap decision: from the current counters decides whether a move-in,
// move-out or flush may proceed (commit) or must trap, computes the trap
// code, and registers it as a one-cycle request.
// Assumes counters are sampled before the operation's own update.
module wsu_trap_unit
    import wsu_pkg::*;
#(
    parameter int              NWIN       = 8,
    parameter int              CW         = 5,
    parameter int              WSW        = 6,
    parameter int              TTW        = 9,
    parameter logic [TTW-1:0]  SPILL_BASE = 9'h080,
    parameter logic [TTW-1:0]  FILL_BASE  = 9'h0C0,
    parameter logic [TTW-1:0]  CLEAN_BASE = 9'h024,
    parameter logic [TTW-1:0]  OTHER_FLAG = 9'h020
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  wsu_op_e         op,
    input  logic [CW-1:0]   free_cnt,
    input  logic [CW-1:0]   refill_cnt,
    input  logic [CW-1:0]   clean_cnt,
    input  logic [CW-1:0]   foreign_cnt,
    input  logic [WSW-1:0]  trap_sel,
    output logic            commit,
    output logic            trap_valid,
    output logic [TTW-1:0]  trap_type
);
    localparam logic [CW-1:0] FLUSH_OK = CW'(NWIN - 2);
    localparam int            HALF     = WSW / 2;

    logic [TTW-1:0] variant;
    logic           req;
    logic [TTW-1:0] code;

    // Variant bits: foreign windows pick the upper field plus the flag.
    always_comb begin
        if (foreign_cnt != '0)
            variant = OTHER_FLAG | (TTW'(trap_sel[WSW-1:HALF]) << 2);
        else
            variant = TTW'(trap_sel[HALF-1:0]) << 2;
    end

    // Decide trap or commit for the presented operation.
    always_comb begin
        req    = 1'b0;
        code   = '0;
        commit = 1'b0;
        if (op_valid) begin
            case (op)
                OP_MOVE_IN: begin
                    if (free_cnt == '0) begin
                        req  = 1'b1;
                        code = SPILL_BASE | variant;
                    end else if (clean_cnt == refill_cnt) begin
                        req  = 1'b1;
                        code = CLEAN_BASE;
                    end else begin
                        commit = 1'b1;
                    end
                end
                OP_MOVE_OUT: begin
                    if (refill_cnt == '0) begin
                        req  = 1'b1;
                        code = FILL_BASE | variant;
                    end else begin
                        commit = 1'b1;
                    end
                end
                OP_FLUSH: begin
                    if (free_cnt != FLUSH_OK) begin
                        req  = 1'b1;
                        code = SPILL_BASE | variant;
                    end
                end
                default: commit = 1'b0;
            endcase
        end
    end

    // Register the request as a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_valid <= 1'b0;
            trap_type  <= '0;
        end else begin
            trap_valid <= req;
            trap_type  <= req ? code : '0;
        end
    end

    // A trap may only follow an operation presented in the previous cycle.
    assert_trap_after_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> $past(op_valid));

    // A flush never commits a counter change.
    assert_flush_no_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_FLUSH) |-> !commit);

endmodule

// File: rtl/wsu_counters.sv
// Counter bank: holds the free, refillable, clean and foreign window
// counts and the trap-selection register, and applies each operation's
// update. Assumes commit already accounts for any trap condition.
module wsu_counters
    import wsu_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int CW   = 5,
    parameter int WSW  = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  wsu_op_e         op,
    input  wsu_sel_e        sel,
    input  logic [WSW-1:0]  wr_val,
    input  logic            commit,
    output logic [CW-1:0]   free_cnt,
    output logic [CW-1:0]   refill_cnt,
    output logic [CW-1:0]   clean_cnt,
    output logic [CW-1:0]   foreign_cnt,
    output logic [WSW-1:0]  trap_sel
);
    localparam logic [CW-1:0] FREE_RST  = CW'(NWIN - 2);
    localparam logic [CW-1:0] CLEAN_MAX = CW'(NWIN - 1);
    localparam logic [CW-1:0] ONE       = CW'(1);

    // Apply resets, moves, spill/fill notes and register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_cnt    <= FREE_RST;
            refill_cnt  <= '0;
            clean_cnt   <= '0;
            foreign_cnt <= '0;
            trap_sel    <= '0;
        end else if (op_valid) begin
            case (op)
                OP_MOVE_IN: begin
                    if (commit) begin
                        free_cnt   <= free_cnt - ONE;
                        refill_cnt <= refill_cnt + ONE;
                    end
                end
                OP_MOVE_OUT: begin
                    if (commit) begin
                        free_cnt   <= free_cnt + ONE;
                        refill_cnt <= refill_cnt - ONE;
                    end
                end
                OP_SPILLED: begin
                    free_cnt <= free_cnt + ONE;
                    if (foreign_cnt != '0) foreign_cnt <= foreign_cnt - ONE;
                    else                   refill_cnt  <= refill_cnt - ONE;
                end
                OP_FILLED: begin
                    if (clean_cnt < CLEAN_MAX) clean_cnt <= clean_cnt + ONE;
                    if (foreign_cnt != '0) begin
                        foreign_cnt <= foreign_cnt - ONE;
                        refill_cnt  <= refill_cnt + ONE;
                    end else begin
                        free_cnt    <= free_cnt - ONE;
                        refill_cnt  <= refill_cnt + ONE;
                    end
                end
                OP_WRITE: begin
                    case (sel)
                        SEL_FREE:    free_cnt    <= wr_val[CW-1:0];
                        SEL_REFILL:  refill_cnt  <= wr_val[CW-1:0];
                        SEL_CLEAN:   clean_cnt   <= wr_val[CW-1:0];
                        SEL_FOREIGN: foreign_cnt <= wr_val[CW-1:0];
                        SEL_TSEL:    trap_sel    <= wr_val;
                        default:     trap_sel    <= trap_sel;
                    endcase
                end
                default: free_cnt <= free_cnt;
            endcase
        end
    end

    // A committed move-in shifts one window from free to refillable.
    assert_move_in_counts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_MOVE_IN && commit) |=>
            (free_cnt == $past(free_cnt) - ONE) && (refill_cnt == $past(refill_cnt) + ONE));

    // The clean count never climbs past its ceiling on a fill note.
    assert_clean_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_FILLED && clean_cnt >= CLEAN_MAX) |=> $stable(clean_cnt));

    // A spill note with foreign windows leaves the refillable count alone.
    assert_spilled_foreign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_SPILLED && foreign_cnt != '0) |=> $stable(refill_cnt));

endmodule

// File: rtl/wsu_pointer.sv
// Window pointer: steps down on a committed move-in and up on a committed
// move-out, with wrap at NWIN, and presents the value in reversed
// numbering. A write is reduced modulo NWIN and stored reversed.
module wsu_pointer
    import wsu_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int DW   = 8,
    parameter int CWPW = $clog2(NWIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  wsu_op_e          op,
    input  wsu_sel_e         sel,
    input  logic [DW-1:0]    wr_data,
    input  logic             commit,
    output logic [CWPW-1:0]  ptr_rd
);
    localparam logic [CWPW-1:0] PTR_MAX = CWPW'(NWIN - 1);
    localparam logic [CWPW-1:0] ONE     = CWPW'(1);

    logic [CWPW-1:0] ptr_q;
    logic [CWPW-1:0] wr_mod;

    // Reduce a written value into the legal window range.
    always_comb wr_mod = CWPW'(32'(wr_data) % NWIN);

    // Step or load the internal pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (op_valid && commit && op == OP_MOVE_IN) begin
            ptr_q <= (ptr_q == '0) ? PTR_MAX : ptr_q - ONE;
        end else if (op_valid && commit && op == OP_MOVE_OUT) begin
            ptr_q <= (ptr_q == PTR_MAX) ? '0 : ptr_q + ONE;
        end else if (op_valid && op == OP_WRITE && sel == SEL_PTR) begin
            ptr_q <= PTR_MAX - wr_mod;
        end
    end

    // Reversed numbering toward software.
    always_comb ptr_rd = PTR_MAX - ptr_q;

    // Move-in advances the read value by one with wrap.
    assert_ptr_in_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && commit && op == OP_MOVE_IN) |=>
            ptr_rd == (($past(ptr_rd) == PTR_MAX) ? '0 : $past(ptr_rd) + ONE));

    // Move-out retreats the read value by one with wrap.
    assert_ptr_out_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && commit && op == OP_MOVE_OUT) |=>
            ptr_rd == (($past(ptr_rd) == '0) ? PTR_MAX : $past(ptr_rd) - ONE));

    // The read value is always a legal window index.
    assert_ptr_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_rd <= PTR_MAX);

endmodule

// File: rtl/win_state_unit.sv
// Top: register-window occupancy tracker. Decodes the operation, lets the
// trap unit decide commit or trap, and drives the counter bank and the
// window pointer. One operation per cycle; traps appear one cycle later.
module win_state_unit
    import wsu_pkg::*;
#(
    parameter int              NWIN       = 8,
    parameter int              CW         = 5,
    parameter int              WSW        = 6,
    parameter int              DW         = 8,
    parameter int              TTW        = 9,
    parameter int              CWPW       = $clog2(NWIN),
    parameter logic [TTW-1:0]  SPILL_BASE = 9'h080,
    parameter logic [TTW-1:0]  FILL_BASE  = 9'h0C0,
    parameter logic [TTW-1:0]  CLEAN_BASE = 9'h024,
    parameter logic [TTW-1:0]  OTHER_FLAG = 9'h020
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [2:0]       op_code,
    input  logic [2:0]       wr_sel,
    input  logic [DW-1:0]    wr_data,
    output logic [CW-1:0]    free_cnt,
    output logic [CW-1:0]    refill_cnt,
    output logic [CW-1:0]    clean_cnt,
    output logic [CW-1:0]    foreign_cnt,
    output logic [WSW-1:0]   trap_sel,
    output logic [CWPW-1:0]  ptr_rd,
    output logic             trap_valid,
    output logic [TTW-1:0]   trap_type
);
    wsu_op_e  op;
    wsu_sel_e sel;
    logic     commit;

    // Decode the raw input codes into enumerated values.
    always_comb begin
        op  = wsu_op_e'(op_code);
        sel = wsu_sel_e'(wr_sel);
    end

    wsu_trap_unit #(
        .NWIN(NWIN), .CW(CW), .WSW(WSW), .TTW(TTW),
        .SPILL_BASE(SPILL_BASE), .FILL_BASE(FILL_BASE),
        .CLEAN_BASE(CLEAN_BASE), .OTHER_FLAG(OTHER_FLAG)
    ) u_trap (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op),
        .free_cnt(free_cnt), .refill_cnt(refill_cnt), .clean_cnt(clean_cnt),
        .foreign_cnt(foreign_cnt), .trap_sel(trap_sel),
        .commit(commit), .trap_valid(trap_valid), .trap_type(trap_type)
    );

    wsu_counters #(.NWIN(NWIN), .CW(CW), .WSW(WSW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .sel(sel),
        .wr_val(wr_data[WSW-1:0]), .commit(commit),
        .free_cnt(free_cnt), .refill_cnt(refill_cnt), .clean_cnt(clean_cnt),
        .foreign_cnt(foreign_cnt), .trap_sel(trap_sel)
    );

    wsu_pointer #(.NWIN(NWIN), .DW(DW), .CWPW(CWPW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .sel(sel),
        .wr_data(wr_data), .commit(commit), .ptr_rd(ptr_rd)
    );

    // A trapped operation leaves every counter and the pointer unchanged.
    assert_trap_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> (free_cnt == $past(free_cnt)) && (refill_cnt == $past(refill_cnt))
                    && (clean_cnt == $past(clean_cnt)) && (ptr_rd == $past(ptr_rd)));

    // No state moves when no operation is presented.
    assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(free_cnt) && $stable(refill_cnt) && $stable(ptr_rd)
                      && $stable(foreign_cnt) && $stable(clean_cnt) && !trap_valid);

endmodule

// File: tb/sim_win_state_unit.sv
// Bench: directed corner cases followed by seeded random operations,
// compared each cycle against a reference model kept in the bench.
module sim_win_state_unit;
    localparam int NWIN = 8;
    localparam logic [8:0] SPB = 9'h080, FLB = 9'h0C0, CLB = 9'h024, OTF = 9'h020;

    logic clk = 1'b0, rst_n = 1'b0, op_valid = 1'b0;
    logic [2:0] op_code = '0, wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [4:0] free_cnt, refill_cnt, clean_cnt, foreign_cnt;
    logic [5:0] trap_sel;
    logic [2:0] ptr_rd;
    logic trap_valid;
    logic [8:0] trap_type;

    int checks = 0, errors = 0;
    logic [4:0] m_fr, m_rf, m_cl, m_fo;
    logic [5:0] m_ts;
    logic [2:0] m_pt;
    logic e_tv;
    logic [8:0] e_tt;

    always #5 clk = ~clk;

    win_state_unit #(.NWIN(NWIN), .SPILL_BASE(SPB), .FILL_BASE(FLB),
                     .CLEAN_BASE(CLB), .OTHER_FLAG(OTF)) u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .wr_sel(wr_sel), .wr_data(wr_data), .free_cnt(free_cnt),
        .refill_cnt(refill_cnt), .clean_cnt(clean_cnt), .foreign_cnt(foreign_cnt),
        .trap_sel(trap_sel), .ptr_rd(ptr_rd), .trap_valid(trap_valid),
        .trap_type(trap_type)
    );

    function automatic logic [8:0] exp_code(input logic [8:0] base);
        if (m_fo != 0) return base | OTF | {4'b0, m_ts[5:3], 2'b00};
        return base | {4'b0, m_ts[2:0], 2'b00};
    endfunction

    task automatic trap(input logic [8:0] code);
        e_tv = 1'b1;
        e_tt = code;
    endtask

    // Model update from the requirements, using pre-operation state.
    task automatic model(input logic v, input logic [2:0] op, input logic [2:0] s,
                         input logic [7:0] d);
        e_tv = 1'b0;
        e_tt = '0;
        if (v) begin
            case (op)
                3'd1: if (m_fr == 0) trap(exp_code(SPB));
                      else if (m_cl == m_rf) trap(CLB);
                      else begin m_fr--; m_rf++; m_pt = (m_pt == 7) ? 3'd0 : m_pt + 3'd1; end
                3'd2: if (m_rf == 0) trap(exp_code(FLB));
                      else begin m_fr++; m_rf--; m_pt = (m_pt == 0) ? 3'd7 : m_pt - 3'd1; end
                3'd3: if (m_fr != 5'(NWIN - 2)) trap(exp_code(SPB));
                3'd4: begin m_fr++; if (m_fo != 0) m_fo--; else m_rf--; end
                3'd5: begin
                    m_rf++;
                    if (m_cl < 5'(NWIN - 1)) m_cl++;
                    if (m_fo != 0) m_fo--; else m_fr--;
                end
                3'd6: case (s)
                    3'd0: m_fr = d[4:0];
                    3'd1: m_rf = d[4:0];
                    3'd2: m_cl = d[4:0];
                    3'd3: m_fo = d[4:0];
                    3'd4: m_ts = d[5:0];
                    3'd5: m_pt = 3'(d % NWIN);
                    default: ;
                endcase
                default: ;
            endcase
        end
    endtask

    task automatic compare(input string tag);
        checks++;
        if (free_cnt !== m_fr || refill_cnt !== m_rf || clean_cnt !== m_cl ||
            foreign_cnt !== m_fo || trap_sel !== m_ts || ptr_rd !== m_pt ||
            trap_valid !== e_tv || (e_tv && trap_type !== e_tt)) begin
            errors++;
            $display("FAIL %s: got fr=%0d rf=%0d cl=%0d fo=%0d ts=%h pt=%0d tv=%0b tt=%h exp fr=%0d rf=%0d cl=%0d fo=%0d ts=%h pt=%0d tv=%0b tt=%h",
                     tag, free_cnt, refill_cnt, clean_cnt, foreign_cnt, trap_sel, ptr_rd,
                     trap_valid, trap_type, m_fr, m_rf, m_cl, m_fo, m_ts, m_pt, e_tv, e_tt);
        end
    endtask

    // Drive one operation at a falling edge, check at the next falling edge.
    task automatic run(input logic v, input logic [2:0] op, input logic [2:0] s,
                       input logic [7:0] d, input string tag);
        op_valid = v; op_code = op; wr_sel = s; wr_data = d;
        model(v, op, s, d);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] seed_val;
        seed_val = $urandom(32'd4711);
        m_fr = 5'(NWIN - 2); m_rf = 0; m_cl = 0; m_fo = 0; m_ts = 0; m_pt = 3'(NWIN - 1);
        e_tv = 0; e_tt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset");
        run(1, 3'd1, 0, 0, "R4 clean-window trap");
        run(1, 3'd6, 3'd2, 8'd7, "R12 write clean");
        run(1, 3'd1, 0, 0, "R2 move-in pointer wrap");
        for (int i = 0; i < 5; i++) run(1, 3'd1, 0, 0, "R2 move-in");
        run(1, 3'd1, 0, 0, "R3 spill at zero free");
        run(1, 3'd6, 3'd4, 8'b0010_1011, "R12 write trap_sel");
        run(1, 3'd1, 0, 0, "R5 spill type low field");
        run(1, 3'd6, 3'd3, 8'd2, "R12 write foreign");
        run(1, 3'd1, 0, 0, "R5 spill type upper field");
        run(1, 3'd3, 0, 0, "R7 flush traps");
        run(1, 3'd4, 0, 0, "R8 spilled foreign");
        run(1, 3'd4, 0, 0, "R8 spilled foreign last");
        run(1, 3'd4, 0, 0, "R8 spilled refill");
        for (int i = 0; i < 5; i++) run(1, 3'd2, 0, 0, "R6 move-out");
        run(1, 3'd2, 0, 0, "R6 fill trap");
        run(0, 3'd1, 0, 0, "R11 invalid ignored");
        run(1, 3'd0, 0, 0, "R11 none ignored");
        run(1, 3'd5, 0, 0, "R9 filled clean saturated");
        run(1, 3'd6, 3'd2, 8'd3, "R12 write clean low");
        run(1, 3'd5, 0, 0, "R9 filled clean grows");
        run(1, 3'd6, 3'd6, 8'd9, "R12 reserved select");
        run(1, 3'd6, 3'd5, 8'd13, "R10 pointer write modulo");
        run(1, 3'd6, 3'd5, 8'd255, "R10 pointer write max");
        run(1, 3'd6, 3'd0, 8'(NWIN - 2), "R12 write free");
        run(1, 3'd3, 0, 0, "R7 flush no trap");
        run(1, 3'd6, 3'd3, 8'd0, "R12 clear foreign");
        run(1, 3'd6, 3'd1, 8'd0, "R12 clear refill");
        run(1, 3'd2, 0, 0, "R5 fill type low field");
        for (int i = 0; i < 600; i++) begin
            int r;
            logic [2:0] op;
            r = $urandom_range(0, 9);
            op = (r < 2) ? 3'd1 : (r < 4) ? 3'd2 : (r == 4) ? 3'd3 : (r == 5) ? 3'd4 :
                 (r == 6) ? 3'd5 : (r == 7) ? 3'd6 : 3'd0;
            run(r != 9, op, 3'($urandom_range(0, 7)), 8'($urandom_range(0, 255)),
                "R2 R5 R6 R8 R9 random mix");
        end
        op_valid = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule